// File: doc/BRIEF.md
# Programmable Serial CRC Engine

This block computes a cyclic redundancy check over a stream of data words, one bit per clock. Software sets a length code L (0 to 15), which makes both the data words and the checksum L+1 bits wide. It also sets a tap mask that picks the feedback points of the shift register. Software seeds the register, queues words into a small input FIFO and raises the go bit. A serial shifter then takes the head word, most significant bit first, and feeds it into the register until the FIFO has drained.

The FIFO is sixteen words deep for short lengths (L of 7 or less) and eight words deep for longer ones. A five-bit counter of queued words is visible at the ports, along with full and empty flags. An interrupt pulse marks the moment the last queued word has been consumed. A suspend input, and an idle input qualified by a stop-in-idle bit, freeze the engine in place. Work resumes from the same bit when the hold is released.

Top module: `crc_serial_engine`

## Requirements
- R1: The checksum is the low L+1 bits of the shift register, and every bit above L of `crc_value` reads 0. Bits of a data word above bit L have no effect on the result.
- R2: The FIFO holds 16 words when L ≤ 7 and 8 words when L > 7. `fifo_full` is 1 exactly when `word_count` equals that depth. `fifo_empty` is 1 exactly when `word_count` is 0.
- R3: An accepted word write raises `word_count` by one. Completing the last bit of a word lowers it by one. If both happen in the same cycle, the count is unchanged.
- R4: Bits are shifted only in cycles where `go` is 1, the count is nonzero and the engine is not held. With `go` at 0, queued words stay queued and the checksum does not change.
- R5: Each word takes exactly L+1 shift cycles, so N queued words drain in (L+1)·N cycles after `go` rises.
- R6: A word write while `fifo_full` is 1 discards the word and sets `word_count` to 0, so the FIFO reads as empty. This wrap raises no interrupt, and afterwards `go` shifts nothing.
- R7: `crc_irq` is a one-cycle pulse. It is 1 exactly in the first cycle in which `word_count` reads 0 after the count drains from 1 to 0.
- R8: While `suspend` is 1, or while `idle` and `stop_in_idle` are both 1, the count, the bit position and the checksum keep their values, and word and seed writes are ignored. Shifting continues under `idle` when `stop_in_idle` is 0. Once the hold is released, shifting resumes where it stopped.
- R9: Per shifted bit, with the data bit d, the feedback is fb = d XOR reg[L]. The new reg[0] is fb, and for 1 ≤ k ≤ L the new reg[k] is reg[k−1] XOR (tap[k] AND fb). Data bits enter from bit L down to bit 0.
- R10: `seed_wr` with `go` at 0 loads the low L+1 bits of `seed_data` into the register. With `go` at 1 the seed write is ignored.
- R11: After reset, `word_count` is 0, `fifo_empty` is 1, `fifo_full` is 0, `crc_value` is 0 and `crc_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poly_len | input | 4 | Length code L; width is L+1 |
| tap_mask | input | 16 | Feedback enables, bit k feeds register bit k |
| go | input | 1 | Enables serial shifting |
| word_wr | input | 1 | Queue `word_data` this cycle |
| word_data | input | 16 | Data word |
| seed_wr | input | 1 | Load seed when `go` is 0 |
| seed_data | input | 16 | Seed value |
| suspend | input | 1 | Freezes the engine |
| idle | input | 1 | Idle request, effective with `stop_in_idle` |
| stop_in_idle | input | 1 | Freeze while `idle` is 1 |
| word_count | output | 5 | Queued word count |
| fifo_full | output | 1 | Count equals current depth |
| fifo_empty | output | 1 | Count is zero |
| crc_value | output | 16 | Checksum, low L+1 bits |
| crc_irq | output | 1 | Drain pulse |

## Verification
All results are registered. A word or seed write shows in `word_count` and `crc_value` on the first edge after it is driven. Each shift cycle after `go` rises moves one bit, so the count falls L+1 edges after shifting of a word begins. `crc_irq` appears in the same cycle that `word_count` first reads 0. The bench drives inputs at falling edges and samples one falling edge after the edge that should update the output. It counts the falling edges from raising `go` until `fifo_empty` returns, and compares that count with (L+1)·N. It counts the `crc_irq` pulses seen over the same window.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

    localparam int unsigned CRC_W        = 16;
    localparam int unsigned LEN_W        = 4;
    localparam int unsigned FIFO_DEEP    = 16;
    localparam int unsigned FIFO_SHALLOW = 8;
    localparam int unsigned LEN_SPLIT    = 7;

    typedef logic [CRC_W-1:0] crc_word_t;
    typedef logic [LEN_W-1:0] crc_len_t;

    typedef struct packed {
        crc_len_t  len;
        crc_word_t taps;
    } crc_cfg_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_HOLD  = 2'd2
    } eng_state_t;

    // Ones in bit positions 0..len.
    function automatic crc_word_t width_mask(input crc_len_t len);
        crc_word_t m;
        for (int k = 0; k < CRC_W; k++) begin
            m[k] = (k <= int'(len));
        end
        return m;
    endfunction

    // One serial step of the feedback register.
    function automatic crc_word_t crc_step(input crc_word_t cur, input logic din,
                                           input crc_cfg_t cfg);
        logic      fb;
        crc_word_t nxt;
        fb     = din ^ cur[cfg.len];
        nxt[0] = fb;
        for (int k = 1; k < CRC_W; k++) begin
            nxt[k] = cur[k-1] ^ (cfg.taps[k] & fb);
        end
        return nxt & width_mask(cfg.len);
    endfunction

endpackage

// File: rtl/crc_word_fifo.sv
module crc_word_fifo
    import crc_eng_pkg::*;
#(
    parameter int unsigned DEEP    = FIFO_DEEP,
    parameter int unsigned SHALLOW = FIFO_SHALLOW,
    parameter int unsigned SPLIT   = LEN_SPLIT,
    localparam int unsigned PTR_W  = $clog2(DEEP),
    localparam int unsigned CNT_W  = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  crc_len_t         len,
    input  logic             push,
    input  crc_word_t        push_data,
    input  logic             pop,
    input  logic             hold,
    output crc_word_t        head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             wrap,
    output logic             drained
);

    crc_word_t        mem [DEEP];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] depth;
    logic             push_ok, do_push;

    assign depth   = (len > LEN_W'(SPLIT)) ? CNT_W'(SHALLOW) : CNT_W'(DEEP);
    assign full    = (count == depth);
    assign empty   = (count == '0);
    assign push_ok = push && !hold;
    assign wrap    = push_ok && full;
    assign do_push = push_ok && !full;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return ({1'b0, p} == depth - CNT_W'(1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            drained <= 1'b0;
        end else begin
            drained <= (count == CNT_W'(1)) && pop && !do_push && !wrap;
            if (wrap) begin
                count  <= '0;
                rd_ptr <= wr_ptr;
            end else begin
                if (do_push) wr_ptr <= advance(wr_ptr);
                if (pop)     rd_ptr <= advance(rd_ptr);
                case ({do_push, pop})
                    2'b10:   count <= count + CNT_W'(1);
                    2'b01:   count <= count - CNT_W'(1);
                    default: count <= count;
                endcase
            end
        end
    end

    assert_wrap_empties_R6: assert property (@(posedge clk) disable iff (rst)
        (push && !hold && full) |=> (empty && !drained));

    assert_push_pop_balance_R3: assert property (@(posedge clk) disable iff (rst)
        (do_push && pop) |=> $stable(count));

    assert_pop_needs_word_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/crc_bit_ctrl.sv
module crc_bit_ctrl
    import crc_eng_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  crc_len_t len,
    input  logic     run,
    input  logic     restart,
    output crc_len_t bit_sel,
    output logic     pop
);

    crc_len_t pos;

    assign pop     = run && (pos == len);
    assign bit_sel = len - pos;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pos <= '0;
        end else if (pop) begin
            pos <= '0;
        end else if (run) begin
            pos <= pos + LEN_W'(1);
        end
    end

    assert_word_restart_R5: assert property (@(posedge clk) disable iff (rst)
        pop |=> (bit_sel == len));

    assert_pos_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(pos));

endmodule

// File: rtl/crc_lfsr.sv
module crc_lfsr
    import crc_eng_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  crc_cfg_t  cfg,
    input  logic      run,
    input  logic      din,
    input  logic      seed_ld,
    input  crc_word_t seed,
    output crc_word_t crc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else if (run) begin
            crc_q <= crc_step(crc_q, din, cfg);
        end else if (seed_ld) begin
            crc_q <= seed & width_mask(cfg.len);
        end
    end

    assert_quiet_register_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && !seed_ld) |=> $stable(crc_q));

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
    import crc_eng_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  poly_len,
    input  logic [15:0] tap_mask,
    input  logic        go,
    input  logic        word_wr,
    input  logic [15:0] word_data,
    input  logic        seed_wr,
    input  logic [15:0] seed_data,
    input  logic        suspend,
    input  logic        idle,
    input  logic        stop_in_idle,
    output logic [4:0]  word_count,
    output logic        fifo_full,
    output logic        fifo_empty,
    output logic [15:0] crc_value,
    output logic        crc_irq
);

    crc_cfg_t   cfg;
    eng_state_t state;
    crc_word_t  head, crc_raw;
    crc_len_t   bit_sel;
    logic       hold, run, pop, wrap, seed_ld;

    assign cfg.len  = poly_len;
    assign cfg.taps = tap_mask;
    assign hold     = suspend || (idle && stop_in_idle);

    always_comb begin
        if (hold)                    state = ENG_HOLD;
        else if (go && !fifo_empty)  state = ENG_SHIFT;
        else                         state = ENG_IDLE;
    end

    assign run     = (state == ENG_SHIFT) && !wrap;
    assign seed_ld = seed_wr && !go && !hold;

    crc_word_fifo u_fifo (
        .clk       (clk),
        .rst       (rst),
        .len       (cfg.len),
        .push      (word_wr),
        .push_data (word_data),
        .pop       (pop),
        .hold      (hold),
        .head      (head),
        .count     (word_count),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .wrap      (wrap),
        .drained   (crc_irq)
    );

    crc_bit_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .len     (cfg.len),
        .run     (run),
        .restart (wrap),
        .bit_sel (bit_sel),
        .pop     (pop)
    );

    crc_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .run     (run),
        .din     (head[bit_sel]),
        .seed_ld (seed_ld),
        .seed    (seed_data),
        .crc_q   (crc_raw)
    );

    assign crc_value = crc_raw & width_mask(cfg.len);

    assert_irq_on_drain_R7: assert property (@(posedge clk) disable iff (rst)
        crc_irq |-> ((word_count == 5'd0) && ($past(word_count) == 5'd1)));

    assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(word_count) && $stable(crc_raw)));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
        crc_irq |=> !crc_irq);

endmodule

// File: tb/sim_crc_serial_engine.sv
`timescale 1ns/1ps
module sim_crc_serial_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  poly_len = 4'd15;
    logic [15:0] tap_mask = 16'h0;
    logic        go = 1'b0, word_wr = 1'b0, seed_wr = 1'b0;
    logic [15:0] word_data = 16'h0, seed_data = 16'h0;
    logic        suspend = 1'b0, idle = 1'b0, stop_in_idle = 1'b0;
    logic [4:0]  word_count;
    logic        fifo_full, fifo_empty, crc_irq;
    logic [15:0] crc_value;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    crc_serial_engine u0 (
        .clk(clk), .rst(rst), .poly_len(poly_len), .tap_mask(tap_mask), .go(go),
        .word_wr(word_wr), .word_data(word_data), .seed_wr(seed_wr),
        .seed_data(seed_data), .suspend(suspend), .idle(idle),
        .stop_in_idle(stop_in_idle), .word_count(word_count), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .crc_value(crc_value), .crc_irq(crc_irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mdl(input logic [15:0] c, input logic [15:0] d,
                                        input int len, input logic [15:0] taps);
        logic [16:0] m;
        logic        top;
        m = (17'd1 << (len + 1)) - 17'd1;
        for (int i = len; i >= 0; i--) begin
            top = c[len] ^ d[i];
            c = c << 1;
            if (top) c = c ^ ((taps & 16'hFFFE) | 16'h0001);
            c = c & m[15:0];
        end
        return c;
    endfunction

    task automatic push(input logic [15:0] d);
        word_wr = 1'b1; word_data = d;
        @(negedge clk);
        word_wr = 1'b0;
    endtask

    task automatic load_seed(input logic [15:0] s);
        seed_wr = 1'b1; seed_data = s;
        @(negedge clk);
        seed_wr = 1'b0;
    endtask

    task automatic drain(output int cyc, output int irqs);
        cyc = 0; irqs = 0;
        go = 1'b1;
        while (!fifo_empty && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (crc_irq) irqs++;
        end
        go = 1'b0;
        @(negedge clk);
        if (crc_irq) irqs++;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #750000;
        checks++; errors++;
        $display("FAIL R5 watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [15:0] exp, snap_crc, words[4];
        logic [4:0]  snap_cnt;
        int cyc, irqs, n, len;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "reset count", word_count, 0);
        chk("R11", "reset empty", fifo_empty, 1);
        chk("R11", "reset full", fifo_full, 0);
        chk("R11", "reset crc", crc_value, 0);
        chk("R11", "reset irq", crc_irq, 0);

        // CCITT polynomial, L=15, taps at 12 and 5
        poly_len = 4'd15; tap_mask = 16'h1020;
        load_seed(16'hFFFF);
        chk("R10", "seed load", crc_value, 16'hFFFF);
        exp = 16'hFFFF;
        words[0] = 16'h1234; words[1] = 16'hABCD; words[2] = 16'h0F0F;
        for (int i = 0; i < 3; i++) begin
            push(words[i]);
            exp = mdl(exp, words[i], 15, 16'h1020);
        end
        chk("R3", "count after 3 writes", word_count, 3);
        drain(cyc, irqs);
        chk("R5", "drain cycles 3x16", cyc, 48);
        chk("R7", "one irq pulse", irqs, 1);
        chk("R9", "ccitt crc", crc_value, exp);

        // seed ignored while go=1
        go = 1'b1;
        load_seed(16'h5555);
        chk("R10", "seed ignored with go", crc_value, exp);
        go = 1'b0;
        @(negedge clk);

        // L=7, upper data bits ignored
        poly_len = 4'd7; tap_mask = 16'h0007;
        load_seed(16'hFFAB);
        chk("R1", "seed masked to 8 bits", crc_value, 16'h00AB);
        push(16'hFF5A);
        drain(cyc, irqs);
        chk("R1", "upper bits ignored", crc_value, mdl(16'h00AB, 16'h005A, 7, 16'h0007));
        chk("R5", "8 cycles one word", cyc, 8);

        // go=0 holds queue and crc
        push(16'h00C3);
        snap_crc = crc_value;
        repeat (20) @(negedge clk);
        chk("R4", "no shift go low crc", crc_value, snap_crc);
        chk("R4", "no shift go low count", word_count, 1);
        drain(cyc, irqs);
        chk("R4", "drains after go", crc_value, mdl(snap_crc, 16'h00C3, 7, 16'h0007));

        // depth 16 for L=7, wrap on full write
        for (int i = 0; i < 15; i++) push(16'(i * 7));
        chk("R2", "not full at 15", fifo_full, 0);
        push(16'h0011);
        chk("R2", "full at 16", fifo_full, 1);
        chk("R2", "count 16", word_count, 16);
        snap_crc = crc_value;
        push(16'h0022);
        chk("R6", "wrap count", word_count, 0);
        chk("R6", "wrap empty", fifo_empty, 1);
        chk("R6", "wrap no irq", crc_irq, 0);
        go = 1'b1;
        repeat (20) @(negedge clk);
        go = 1'b0;
        chk("R6", "no shift after wrap", crc_value, snap_crc);

        // depth 8 for L=8
        poly_len = 4'd8; tap_mask = 16'h0031;
        load_seed(16'h0000);
        exp = 16'h0;
        for (int i = 0; i < 7; i++) begin
            push(16'(i * 37 + 5));
            exp = mdl(exp, 16'(i * 37 + 5), 8, 16'h0031);
        end
        chk("R2", "not full at 7", fifo_full, 0);
        push(16'h01FF);
        exp = mdl(exp, 16'h01FF, 8, 16'h0031);
        chk("R2", "full at 8", fifo_full, 1);
        drain(cyc, irqs);
        chk("R5", "72 cycles", cyc, 72);
        chk("R9", "len 8 crc", crc_value, exp);

        // hold behaviour
        poly_len = 4'd15; tap_mask = 16'h8005;
        load_seed(16'h0000);
        push(16'hBEEF); push(16'h1357);
        exp = mdl(mdl(16'h0, 16'hBEEF, 15, 16'h8005), 16'h1357, 15, 16'h8005);
        go = 1'b1;
        repeat (5) @(negedge clk);
        suspend = 1'b1;
        snap_crc = crc_value; snap_cnt = word_count;
        push(16'hFFFF);
        go = 1'b0; load_seed(16'h1111); go = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8", "suspend crc frozen", crc_value, snap_crc);
        chk("R8", "suspend count frozen", word_count, snap_cnt);
        suspend = 1'b0; idle = 1'b1; stop_in_idle = 1'b0;
        repeat (16) @(negedge clk);
        chk("R8", "idle without stop runs", word_count, 1);
        stop_in_idle = 1'b1;
        snap_crc = crc_value;
        repeat (6) @(negedge clk);
        chk("R8", "idle stop frozen", crc_value, snap_crc);
        idle = 1'b0; stop_in_idle = 1'b0;
        drain(cyc, irqs);
        chk("R8", "resume exact crc", crc_value, exp);
        chk("R7", "irq after resume", irqs, 1);

        // random lengths, taps, seeds
        for (int t = 0; t < 30; t++) begin
            len = 3 + int'($urandom_range(12));
            poly_len = 4'(len);
            tap_mask = 16'($urandom);
            exp = 16'($urandom);
            load_seed(exp);
            exp = exp & 16'((17'd1 << (len + 1)) - 17'd1);
            n = 1 + int'($urandom_range(3));
            for (int i = 0; i < n; i++) begin
                words[i] = 16'($urandom);
                push(words[i]);
                exp = mdl(exp, words[i], len, tap_mask);
            end
            drain(cyc, irqs);
            chk("R9", "random crc", crc_value, exp);
            chk("R5", "random cycles", cyc, (len + 1) * n);
            chk("R7", "random irq", irqs, 1);
        end

        finish_run();
    end

endmodule